// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared, single-transaction-per-cycle bus. The cache is direct-mapped. Each line holds one data word, an address tag and a coherence state: Invalid, Shared or Modified. The processor side accepts one read or write at a time. Reads that hit and writes to a line already Modified finish locally. Every other access becomes a bus request, and the request is presented until an external arbiter grants it.

The snoop side watches the transactions that other caches put on the bus. It sees each one in the same cycle as every peer, which puts writes to one address into a single order. A read or write-miss that hits a Modified line makes this cache drive its word onto the snoop data port. A read of a Modified line also writes that word back to memory. Write-misses and upgrades remove any copy held here.

A write to a Shared line uses a data-less upgrade instead of a full write-miss. A Modified victim is written back before its slot is refilled. The bus command is re-derived from the line's current state in every cycle while the request waits for its grant. As a result, a snoop that lands during the wait changes what is asked for.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_done` and `snp_supply` are low, and no snooped transaction is answered with data.
- R2: A read that misses, where the indexed slot is not a Modified line of another tag, requests a bus read (`bus_cmd` 0) at the request address. In the grant cycle the line is filled Shared with `bus_rdata`. The next cycle shows `cpu_done` high for one cycle, with that word on `cpu_rdata`.
- R3: Two kinds of access complete with no bus request: a read that hits a Shared or Modified line, and a write that hits a Modified line. `cpu_done` rises two cycles after `cpu_req` is sampled, and `cpu_rdata` then carries the line word after the access.
- R4: A write that hits a Shared line requests an upgrade (`bus_cmd` 2) with no data. On grant the line becomes Modified and holds `cpu_wdata`.
- R5: A write that misses requests a read-for-write (`bus_cmd` 1). On grant the line becomes Modified and holds `cpu_wdata`.
- R6: A snooped read (`snp_cmd` 0) that hits a Modified line raises `snp_supply` with the line word on `snp_data`, which memory also takes as a writeback, and the line becomes Shared. A snooped read that hits a Shared line causes nothing.
- R7: A snooped read-for-write that hits a Modified line raises `snp_supply` with the word, and the line becomes Invalid. A snooped read-for-write or upgrade (`snp_cmd` 2) that hits a Shared line makes it Invalid. A snooped writeback (`snp_cmd` 3) causes nothing.
- R8: When the slot for a missing access holds a Modified line of another tag, a writeback (`bus_cmd` 3) is requested first. It carries the victim address {victim tag, index} and the victim word on `bus_wdata`. After its grant the slot is Invalid, and the miss command follows.
- R9: While a request waits, its command follows the current line state. An upgrade whose line is invalidated by a snoop becomes a read-for-write. A writeback whose victim is downgraded by a snooped read is dropped. A waiting request with no snoop and no grant keeps its command and address.
- R10: A local hit does not complete in a cycle that carries a snooped transaction and completes in the next free cycle. Snoop inputs are ignored in a cycle with `bus_gnt`. `cpu_req` is ignored while an access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, sampled when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits index the line |
| cpu_wdata | input | DATA_W | Write word |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line word after the access, valid with `cpu_done` |
| bus_req | output | 1 | Bus transaction wanted |
| bus_gnt | input | 1 | This cycle's bus transaction is ours |
| bus_cmd | output | 2 | 0 read, 1 read-for-write, 2 upgrade, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback word |
| bus_rdata | input | DATA_W | Fill word returned in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Its command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Its address |
| snp_supply | output | 1 | This cache answers with data |
| snp_data | output | DATA_W | Word supplied |

## Verification
The hardest cases are races between a waiting request and a foreign transaction to the same line. In one, a pending upgrade is hit by another cache's read-for-write. In another, a Modified victim is downgraded by a snooped read before its writeback is granted. The bench reaches both by issuing the processor access, holding back the grant, and injecting the snoop in the intervening cycle. A long randomized phase then mixes requests, grants and snoops over a few aliasing addresses. A behavioural model is compared on every clock so that each re-derived command is caught.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_RDX = 2'd1,
        CMD_UPG = 2'd2,
        CMD_WB  = 2'd3
    } bus_cmd_e;

endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_st_e          wr_st,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data
);

    localparam int LINES = 1 << IDX_W;

    line_st_e          st_all   [LINES];
    logic [TAG_W-1:0]  tag_all  [LINES];
    logic [DATA_W-1:0] data_all [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_st_e          st_d,   st_q;
        logic [TAG_W-1:0]  tag_d,  tag_q;
        logic [DATA_W-1:0] data_d, data_q;
        logic              sel;

        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_comb begin
            st_d   = st_q;
            tag_d  = tag_q;
            data_d = data_q;
            if (sel) begin
                st_d   = wr_st;
                tag_d  = wr_tag;
                data_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q   <= ST_I;
                tag_q  <= '0;
                data_q <= '0;
            end else begin
                st_q   <= st_d;
                tag_q  <= tag_d;
                data_q <= data_d;
            end
        end

        assign st_all[g]   = st_q;
        assign tag_all[g]  = tag_q;
        assign data_all[g] = data_q;
    end

    assign a_st   = st_all[a_idx];
    assign a_tag  = tag_all[a_idx];
    assign a_data = data_all[a_idx];
    assign b_st   = st_all[b_idx];
    assign b_tag  = tag_all[b_idx];
    assign b_data = data_all[b_idx];

endmodule

// File: rtl/msi_snoop_resp.sv
module msi_snoop_resp
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             active,
    input  bus_cmd_e         cmd,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] snp_tag,
    output logic             supply,
    output logic             upd,
    output line_st_e         nst
);

    logic hit;

    always_comb begin
        hit    = active && (st != ST_I) && (line_tag == snp_tag);
        supply = 1'b0;
        upd    = 1'b0;
        nst    = st;
        if (hit) begin
            unique case (cmd)
                CMD_RD: begin
                    if (st == ST_M) begin
                        supply = 1'b1;
                        upd    = 1'b1;
                        nst    = ST_S;
                    end
                end
                CMD_RDX: begin
                    supply = (st == ST_M);
                    upd    = 1'b1;
                    nst    = ST_I;
                end
                CMD_UPG: begin
                    upd = 1'b1;
                    nst = ST_I;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/msi_req_select.sv
module msi_req_select
    import msi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             pend,
    input  logic             we,
    input  logic [TAG_W-1:0] req_tag,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             need,
    output bus_cmd_e         cmd
);

    logic tag_eq;
    logic hit;
    logic local_ok;

    always_comb begin
        tag_eq   = (line_tag == req_tag);
        hit      = (st != ST_I) && tag_eq;
        local_ok = hit && (!we || st == ST_M);
        need     = pend && !local_ok;
        if (st == ST_M && !tag_eq) begin
            cmd = CMD_WB;
        end else if (we && hit) begin
            cmd = CMD_UPG;
        end else if (we) begin
            cmd = CMD_RDX;
        end else begin
            cmd = CMD_RD;
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              pend;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              done;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;
    bus_cmd_e          snp_cmd_e;
    logic              snoop_act;

    line_st_e          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;

    logic              need;
    bus_cmd_e          req_cmd;
    logic              sn_upd;
    line_st_e          sn_nst;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    line_st_e          wr_st;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    assign req_idx   = ctl_q.addr[IDX_W-1:0];
    assign req_tag   = ctl_q.addr[ADDR_W-1:IDX_W];
    assign snp_idx   = snp_addr[IDX_W-1:0];
    assign snp_tag   = snp_addr[ADDR_W-1:IDX_W];
    assign snp_cmd_e = bus_cmd_e'(snp_cmd);
    assign snoop_act = snp_valid && !bus_gnt;

    msi_line_array #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W),
        .DATA_W(DATA_W)
    ) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_st  (wr_st),
        .wr_tag (wr_tag),
        .wr_data(wr_data),
        .a_idx  (req_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .b_idx  (snp_idx),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data)
    );

    msi_req_select #(
        .TAG_W(TAG_W)
    ) u_sel (
        .pend    (ctl_q.pend),
        .we      (ctl_q.we),
        .req_tag (req_tag),
        .st      (a_st),
        .line_tag(a_tag),
        .need    (need),
        .cmd     (req_cmd)
    );

    msi_snoop_resp #(
        .TAG_W(TAG_W)
    ) u_snoop (
        .active  (snoop_act),
        .cmd     (snp_cmd_e),
        .st      (b_st),
        .line_tag(b_tag),
        .snp_tag (snp_tag),
        .supply  (snp_supply),
        .upd     (sn_upd),
        .nst     (sn_nst)
    );

    assign snp_data  = b_data;
    assign bus_req   = need;
    assign bus_cmd   = req_cmd;
    assign bus_addr  = (req_cmd == CMD_WB) ? {a_tag, req_idx} : ctl_q.addr;
    assign bus_wdata = a_data;
    assign cpu_done  = ctl_q.done;
    assign cpu_rdata = ctl_q.rdata;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        wr_en      = 1'b0;
        wr_idx     = snp_idx;
        wr_st      = sn_nst;
        wr_tag     = b_tag;
        wr_data    = b_data;

        // foreign transaction: state change of the snooped line
        if (snoop_act && sn_upd) begin
            wr_en = 1'b1;
        end

        if (ctl_q.pend) begin
            if (bus_gnt && need) begin
                wr_en  = 1'b1;
                wr_idx = req_idx;
                unique case (req_cmd)
                    CMD_WB: begin
                        wr_st   = ST_I;
                        wr_tag  = a_tag;
                        wr_data = a_data;
                    end
                    CMD_RD: begin
                        wr_st       = ST_S;
                        wr_tag      = req_tag;
                        wr_data     = bus_rdata;
                        ctl_d.rdata = bus_rdata;
                        ctl_d.done  = 1'b1;
                        ctl_d.pend  = 1'b0;
                    end
                    default: begin
                        wr_st       = ST_M;
                        wr_tag      = req_tag;
                        wr_data     = ctl_q.wdata;
                        ctl_d.rdata = ctl_q.wdata;
                        ctl_d.done  = 1'b1;
                        ctl_d.pend  = 1'b0;
                    end
                endcase
            end else if (!need && !snoop_act) begin
                // local hit: no bus traffic
                if (ctl_q.we) begin
                    wr_en       = 1'b1;
                    wr_idx      = req_idx;
                    wr_st       = ST_M;
                    wr_tag      = req_tag;
                    wr_data     = ctl_q.wdata;
                    ctl_d.rdata = ctl_q.wdata;
                end else begin
                    ctl_d.rdata = a_data;
                end
                ctl_d.done = 1'b1;
                ctl_d.pend = 1'b0;
            end
        end else if (cpu_req) begin
            ctl_d.pend  = 1'b1;
            ctl_d.we    = cpu_we;
            ctl_d.addr  = cpu_addr;
            ctl_d.wdata = cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_supply
);

    logic snp_live;
    assign snp_live = snp_valid && !bus_gnt;

    assert_quiet_after_reset_R1: assert property (
        @(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!cpu_done && !bus_req && !snp_supply)
    );

    // second snooped read of the same word finds it Shared
    assert_read_downgrades_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(snp_live && snp_supply && snp_cmd == 2'd0)
         && snp_live && snp_cmd == 2'd0 && snp_addr == $past(snp_addr))
        |-> !snp_supply
    );

    // after supplying to a read-for-write the copy is gone
    assert_rdx_invalidates_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        ($past(snp_live && snp_supply && snp_cmd == 2'd1)
         && snp_live && snp_addr == $past(snp_addr))
        |-> !snp_supply
    );

    assert_done_pulse_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done
    );

    assert_done_clears_req_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req
    );

    assert_req_holds_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid)
        |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr))
    );

    // completion data is never unknown
    assert_rdata_known_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        cpu_done |-> !$isunknown(cpu_rdata)
    );

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/msi_snoop_ctrl_test.sv
module msi_snoop_ctrl_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int IW = 2;
    localparam int TW = AW - IW;
    localparam int NL = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_supply;
    logic [DW-1:0] snp_data;

    always #2 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) uut (.*);

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model: 0 Invalid, 1 Shared, 2 Modified
    int            m_st  [NL];
    logic [TW-1:0] m_tag [NL];
    logic [DW-1:0] m_dat [NL];
    logic [DW-1:0] mem   [256];
    bit            m_pend, m_we, m_done;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata, m_rdata;

    task automatic chk(bit ok, string r, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    function automatic bit m_hit();
        int i = int'(m_addr[IW-1:0]);
        return m_st[i] != 0 && m_tag[i] == m_addr[AW-1:IW];
    endfunction

    function automatic bit m_need();
        int i = int'(m_addr[IW-1:0]);
        return m_pend && !(m_hit() && (!m_we || m_st[i] == 2));
    endfunction

    function automatic int m_cmd();
        int i = int'(m_addr[IW-1:0]);
        if (m_st[i] == 2 && m_tag[i] != m_addr[AW-1:IW]) return 3;
        if (m_we && m_hit()) return 2;
        if (m_we) return 1;
        return 0;
    endfunction

    function automatic logic [AW-1:0] m_baddr();
        int i = int'(m_addr[IW-1:0]);
        if (m_cmd() == 3) return {m_tag[i], m_addr[IW-1:0]};
        return m_addr;
    endfunction

    // one clock: compare at negedge+1, advance model, wait next negedge
    task automatic cycle();
        bit            need = m_need();
        int            cmd  = m_cmd();
        logic [AW-1:0] ba   = m_baddr();
        int            idx  = int'(m_addr[IW-1:0]);
        bit            snp, shit, sup, done_n;
        int            sidx;
        string         r, rc;
        if (bus_gnt) bus_rdata = mem[ba];
        #1;
        r = (m_pend && snp_valid) ? "R10" : "R3";
        chk(cpu_done == m_done, r, "cpu_done", int'(cpu_done), int'(m_done));
        if (m_done) chk(cpu_rdata == m_rdata, "R2", "cpu_rdata", int'(cpu_rdata), int'(m_rdata));
        chk(bus_req == need, "R9", "bus_req", int'(bus_req), int'(need));
        if (need) begin
            rc = (cmd == 0) ? "R2" : (cmd == 1) ? "R5" : (cmd == 2) ? "R4" : "R8";
            chk(int'(bus_cmd) == cmd, rc, "bus_cmd", int'(bus_cmd), cmd);
            chk(bus_addr == ba, rc, "bus_addr", int'(bus_addr), int'(ba));
            if (cmd == 3) chk(bus_wdata == m_dat[idx], "R8", "bus_wdata", int'(bus_wdata), int'(m_dat[idx]));
        end
        snp  = snp_valid && !bus_gnt;
        sidx = int'(snp_addr[IW-1:0]);
        shit = snp && m_st[sidx] != 0 && m_tag[sidx] == snp_addr[AW-1:IW];
        sup  = shit && m_st[sidx] == 2 && (snp_cmd == 2'd0 || snp_cmd == 2'd1);
        rc   = (snp_cmd == 2'd0) ? "R6" : "R7";
        chk(snp_supply == sup, rc, "snp_supply", int'(snp_supply), int'(sup));
        if (sup) chk(snp_data == m_dat[sidx], rc, "snp_data", int'(snp_data), int'(m_dat[sidx]));

        done_n = 0;
        if (sup && snp_cmd == 2'd0) mem[snp_addr] = m_dat[sidx];
        if (shit) begin
            case (snp_cmd)
                2'd0: if (m_st[sidx] == 2) m_st[sidx] = 1;
                2'd1, 2'd2: m_st[sidx] = 0;
                default: ;
            endcase
        end
        if (m_pend) begin
            if (bus_gnt && need) begin
                case (cmd)
                    3: begin mem[ba] = m_dat[idx]; m_st[idx] = 0; end
                    0: begin
                        m_st[idx] = 1; m_tag[idx] = m_addr[AW-1:IW];
                        m_dat[idx] = mem[ba]; m_rdata = mem[ba];
                        done_n = 1; m_pend = 0;
                    end
                    default: begin
                        m_st[idx] = 2; m_tag[idx] = m_addr[AW-1:IW];
                        m_dat[idx] = m_wdata; m_rdata = m_wdata;
                        done_n = 1; m_pend = 0;
                    end
                endcase
            end else if (!need && !snp) begin
                if (m_we) m_dat[idx] = m_wdata;
                m_rdata = m_dat[idx];
                done_n = 1; m_pend = 0;
            end
        end else if (cpu_req) begin
            m_pend = 1; m_we = cpu_we; m_addr = cpu_addr; m_wdata = cpu_wdata;
        end
        m_done = done_n;
        @(negedge clk);
        cpu_req = 0; snp_valid = 0; bus_gnt = 0;
    endtask

    task automatic issue(bit we, logic [AW-1:0] a, logic [DW-1:0] d);
        cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_req = 1;
        cycle();
    endtask

    task automatic finish_op();
        while (m_pend) begin
            if (m_need()) bus_gnt = 1;
            cycle();
        end
        cycle();
    endtask

    task automatic snoop(logic [1:0] c, logic [AW-1:0] a);
        snp_valid = 1; snp_cmd = c; snp_addr = a;
        cycle();
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R3 watchdog: actual hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0; end
        for (int i = 0; i < 256; i++) mem[i] = DW'(i * 37 + 5);
        m_pend = 0; m_we = 0; m_done = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        chk(!bus_req && !cpu_done && !snp_supply, "R1", "idle after reset",
            int'({bus_req, cpu_done, snp_supply}), 0);
        @(negedge clk);
        // R1: all lines Invalid, so a snooped read-for-write gets no data
        snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h05;
        #1;
        chk(!snp_supply, "R1", "snoop on empty cache", int'(snp_supply), 0);
        cycle();

        issue(0, 8'h05, '0); finish_op();               // R2 read miss
        issue(0, 8'h05, '0); finish_op();               // R3 read hit Shared
        issue(1, 8'h05, 16'hA1A1); finish_op();         // R4 upgrade
        issue(1, 8'h05, 16'hB2B2); finish_op();         // R3 write hit Modified
        snoop(2'd0, 8'h05);                             // R6 supply and downgrade
        snoop(2'd0, 8'h05);                             // R6 Shared: nothing
        issue(1, 8'h05, 16'hC3C3);                      // R9 upgrade pending
        snoop(2'd1, 8'h05);                             // invalidated meanwhile
        finish_op();                                    // now read-for-write
        issue(1, 8'h09, 16'h1234); finish_op();         // R5 write miss
        issue(0, 8'h0D, '0); finish_op();               // R8 writeback then read
        issue(1, 8'h0D, 16'h5555); finish_op();
        issue(0, 8'h11, '0);                            // R9 victim Modified
        snoop(2'd0, 8'h0D);                             // downgraded: no writeback
        finish_op();
        issue(1, 8'h02, 16'h7777); finish_op();
        snoop(2'd1, 8'h02);                             // R7 supply, Invalid
        snoop(2'd1, 8'h02);
        issue(0, 8'h11, '0);                            // R10 hit deferred by snoop
        snoop(2'd3, 8'h22);
        finish_op();
        issue(0, 8'h03, '0);                            // R10 request while pending
        issue(1, 8'h07, 16'hDEAD);
        finish_op();
        issue(0, 8'h03, '0); finish_op();
        snoop(2'd2, 8'h03);                             // R7 upgrade invalidates
        snoop(2'd3, 8'h11);                             // R7 writeback ignored

        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 25) begin
                cpu_req = 1; cpu_we = $urandom_range(0, 1);
                cpu_addr = {TW'($urandom_range(0, 2)), IW'($urandom_range(0, NL - 1))};
                cpu_wdata = DW'($urandom);
            end
            if (r >= 25 && r < 55 && m_need()) bus_gnt = 1;
            else if (r >= 55 && r < 80) begin
                snp_valid = 1; snp_cmd = 2'($urandom_range(0, 3));
                snp_addr = {TW'($urandom_range(0, 2)), IW'($urandom_range(0, NL - 1))};
            end
            cycle();
        end
        finish_op();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule